// File: doc/BRIEF.md
# MSI Snooping Cache Coherence Controller

This block is the coherence engine of one private cache in a shared-bus multiprocessor. It keeps, for each line of a small direct-mapped cache, a one-word data entry, an address tag and a coherence state of Invalid, Shared or Modified. On the processor side it accepts single-word reads and writes and answers each one with a one-cycle done pulse and, for reads, the data. On the bus side it asks an external arbiter for the bus and, once granted, issues a read-for-share, a read-for-ownership or a write-back of a dirty victim. The bus is atomic: a fetch holds it until the response word arrives.

At the same time the block watches the transactions that other caches put on the bus. When another cache fetches a line that this cache holds dirty, it drives the word onto the supply lines in the same cycle and raises a memory-inhibit signal so that memory stays silent. On a snooped read the line drops to Shared and the supplied word is expected to be written into memory. On a snooped read-for-ownership the line is invalidated, whatever its state.

The controller is a four-state machine. `IDLE` waits for a processor request; `IDLE -> RESP` completes a hit locally; `IDLE -> REQ` starts a miss or an ownership upgrade; `IDLE` holds while a snoop is present. In `REQ` the bus request is raised; a grant takes `REQ -> REQ` when a dirty victim is written back, or `REQ -> FILL` when the fetch is issued. `FILL -> RESP` happens when the response word arrives, and `RESP -> IDLE` ends the request with the done pulse.

Top module: `msi_snoop_ctrl`

## Requirements
- R1: A read that misses (line Invalid or tag different and victim not Modified) issues one read-for-share command (bus_cmd = 1) with the request address; the line is filled Shared, and the response word is returned with cpu_done three cycles after the request is first seen.
- R2: A write to a line that is not Modified issues one read-for-ownership command (bus_cmd = 2) with the request address; the line ends Modified holding the written word, and later reads return that word without bus traffic.
- R3: A snooped read-for-ownership (snp_cmd = 2) that matches a Shared line invalidates it without raising mem_inhibit, so the next local read of that address issues a read-for-share.
- R4: A snooped read-for-share (snp_cmd = 1) that matches a Modified line raises mem_inhibit and drives the line's word on supply_data in that cycle; the line becomes Shared, so a local read still hits and a local write issues a read-for-ownership.
- R5: A snooped read-for-ownership that matches a Modified line raises mem_inhibit, drives the line's word on supply_data, and invalidates the line; a repeated snoop then gets no inhibit and a local read issues a read-for-share.
- R6: mem_inhibit is raised only during a valid snoop that matches a Modified line; a snoop that hits Shared or misses leaves it low.
- R7: A read hit in Shared or Modified issues no bus command and gives cpu_done one cycle after the request is seen.
- R8: A write hit in Modified issues no bus command, updates the line, and gives cpu_done one cycle after the request is seen; cpu_done is always a single-cycle pulse.
- R9: When a processor request and a snoop arrive in the same cycle, the snoop is applied first and the request is evaluated one cycle later against the updated line state.
- R10: A miss whose victim line is Modified first issues a write-back (bus_cmd = 3) carrying the victim's address and word, and only then the read-for-share or read-for-ownership of the new address.
- R11: After reset every line is Invalid, cpu_done and bus_req are low, bus_cmd is 0 and no snoop raises mem_inhibit.
- R12: bus_req stays high from the miss decision until the command is issued, and a bus command is driven only while bus_gnt is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request, held until cpu_done |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address; low bits select the line, the rest form the tag |
| cpu_wdata | input | DATA_W | Write word |
| cpu_rdata | output | DATA_W | Read word, valid with cpu_done |
| cpu_done | output | 1 | One-cycle completion pulse |
| bus_req | output | 1 | Request to the bus arbiter |
| bus_gnt | input | 1 | Grant from the bus arbiter |
| bus_cmd | output | 2 | 0 none, 1 read-for-share, 2 read-for-ownership, 3 write-back |
| bus_addr | output | ADDR_W | Address of the issued command |
| bus_wdata | output | DATA_W | Word carried by a write-back |
| bus_resp_valid | input | 1 | Response word for the outstanding fetch is present |
| bus_resp_data | input | DATA_W | Response word |
| snp_valid | input | 1 | Another cache's transaction is on the bus |
| snp_cmd | input | 2 | Snooped command, same encoding as bus_cmd |
| snp_addr | input | ADDR_W | Snooped address |
| mem_inhibit | output | 1 | This cache supplies the word; memory must not answer |
| supply_data | output | DATA_W | Word supplied on a snoop hit to a Modified line |

## Verification
The assertions assume that the processor holds cpu_addr, cpu_we and cpu_wdata steady from cpu_req until cpu_done, that a snoop never arrives while this cache holds the grant or waits for its fill, and that a response word comes only after this cache issued a fetch. The bench meets this by driving the processor through one task that holds the request until the done pulse, by gating its grant model off whenever it drives a snoop, and by answering a fetch exactly one cycle after the command with a memory model that also takes in write-backs and snoop-read supplies.

// File: rtl/msi_pkg.sv
package msi_pkg;

    typedef enum logic [1:0] {
        LN_I = 2'd0,
        LN_S = 2'd1,
        LN_M = 2'd2
    } line_st_t;

    typedef enum logic [1:0] {
        BC_NONE  = 2'd0,
        BC_RD    = 2'd1,
        BC_RDX   = 2'd2,
        BC_FLUSH = 2'd3
    } bus_cmd_t;

    typedef enum logic [1:0] {
        FS_IDLE = 2'd0,
        FS_REQ  = 2'd1,
        FS_FILL = 2'd2,
        FS_RESP = 2'd3
    } ctrl_st_t;

endpackage

// File: rtl/msi_line_store.sv
module msi_line_store
    import msi_pkg::*;
#(
    parameter int LINES  = 4,
    parameter int TAG_W  = 6,
    parameter int DATA_W = 16,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    // processor-side read port
    input  logic [IDX_W-1:0]  a_idx,
    output line_st_t          a_st,
    output logic [TAG_W-1:0]  a_tag,
    output logic [DATA_W-1:0] a_data,
    // snoop-side read port
    input  logic [IDX_W-1:0]  b_idx,
    output line_st_t          b_st,
    output logic [TAG_W-1:0]  b_tag,
    output logic [DATA_W-1:0] b_data,
    // controller write port
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  line_st_t          wr_st,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic              wr_data_en,
    input  logic [DATA_W-1:0] wr_data,
    // snoop state update at b_idx
    input  logic              snp_en,
    input  line_st_t          snp_st
);

    line_st_t          st_q   [LINES];
    logic [TAG_W-1:0]  tag_q  [LINES];
    logic [DATA_W-1:0] data_q [LINES];

    assign a_st   = st_q[a_idx];
    assign a_tag  = tag_q[a_idx];
    assign a_data = data_q[a_idx];
    assign b_st   = st_q[b_idx];
    assign b_tag  = tag_q[b_idx];
    assign b_data = data_q[b_idx];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LINES; i++) st_q[i] <= LN_I;
        end else begin
            if (wr_en) st_q[wr_idx] <= wr_st;
            if (snp_en) st_q[b_idx] <= snp_st;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx] <= wr_tag;
            if (wr_data_en) data_q[wr_idx] <= wr_data;
        end
    end

endmodule

// File: rtl/msi_snoop_resp.sv
module msi_snoop_resp
    import msi_pkg::*;
#(
    parameter int TAG_W  = 6,
    parameter int DATA_W = 16
) (
    input  logic              snp_valid,
    input  bus_cmd_t          snp_cmd,
    input  logic [TAG_W-1:0]  snp_tag,
    input  line_st_t          ln_st,
    input  logic [TAG_W-1:0]  ln_tag,
    input  logic [DATA_W-1:0] ln_data,
    output logic              inhibit,
    output logic [DATA_W-1:0] supply,
    output logic              upd_en,
    output line_st_t          upd_st
);

    logic hit;
    assign hit = snp_valid && (ln_st != LN_I) && (ln_tag == snp_tag);

    always_comb begin
        inhibit = 1'b0;
        upd_en  = 1'b0;
        upd_st  = ln_st;
        unique case (snp_cmd)
            BC_RD: begin
                if (hit && ln_st == LN_M) begin
                    inhibit = 1'b1;
                    upd_en  = 1'b1;
                    upd_st  = LN_S;
                end
            end
            BC_RDX: begin
                if (hit) begin
                    inhibit = (ln_st == LN_M);
                    upd_en  = 1'b1;
                    upd_st  = LN_I;
                end
            end
            default: ;
        endcase
        supply = inhibit ? ln_data : '0;
    end

endmodule

// File: rtl/msi_snoop_ctrl.sv
module msi_snoop_ctrl
    import msi_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int LINES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_done,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic [1:0]        bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_resp_valid,
    input  logic [DATA_W-1:0] bus_resp_data,
    input  logic              snp_valid,
    input  logic [1:0]        snp_cmd,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              mem_inhibit,
    output logic [DATA_W-1:0] supply_data
);

    localparam int IDX_W = $clog2(LINES);
    localparam int TAG_W = ADDR_W - IDX_W;

    ctrl_st_t state_q, state_d;

    logic [IDX_W-1:0]  c_idx;
    logic [TAG_W-1:0]  c_tag;
    line_st_t          a_st, b_st;
    logic [TAG_W-1:0]  a_tag, b_tag;
    logic [DATA_W-1:0] a_data, b_data;

    logic              wr_en, wr_data_en;
    line_st_t          wr_st;
    logic [TAG_W-1:0]  wr_tag;
    logic [DATA_W-1:0] wr_data;
    logic              snp_en;
    line_st_t          snp_st;

    logic     tag_hit, go, local_done, need_wb;
    bus_cmd_t issue_cmd;

    assign c_idx = cpu_addr[IDX_W-1:0];
    assign c_tag = cpu_addr[ADDR_W-1:IDX_W];

    msi_line_store #(.LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W)) i_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .a_idx      (c_idx),
        .a_st       (a_st),
        .a_tag      (a_tag),
        .a_data     (a_data),
        .b_idx      (snp_addr[IDX_W-1:0]),
        .b_st       (b_st),
        .b_tag      (b_tag),
        .b_data     (b_data),
        .wr_en      (wr_en),
        .wr_idx     (c_idx),
        .wr_st      (wr_st),
        .wr_tag     (wr_tag),
        .wr_data_en (wr_data_en),
        .wr_data    (wr_data),
        .snp_en     (snp_en),
        .snp_st     (snp_st)
    );

    msi_snoop_resp #(.TAG_W(TAG_W), .DATA_W(DATA_W)) i_snoop (
        .snp_valid (snp_valid),
        .snp_cmd   (bus_cmd_t'(snp_cmd)),
        .snp_tag   (snp_addr[ADDR_W-1:IDX_W]),
        .ln_st     (b_st),
        .ln_tag    (b_tag),
        .ln_data   (b_data),
        .inhibit   (mem_inhibit),
        .supply    (supply_data),
        .upd_en    (snp_en),
        .upd_st    (snp_st)
    );

    // Lookup against the current line state; re-evaluated every cycle so
    // snoops that land while waiting for the grant are taken into account.
    assign tag_hit    = (a_st != LN_I) && (a_tag == c_tag);
    assign go         = (state_q == FS_IDLE) && cpu_req && !snp_valid;
    assign local_done = go && tag_hit && (!cpu_we || a_st == LN_M);
    assign need_wb    = (a_st == LN_M) && (a_tag != c_tag);
    assign issue_cmd  = need_wb ? BC_FLUSH : (cpu_we ? BC_RDX : BC_RD);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FS_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpu_rdata <= '0;
        end else if (local_done) begin
            cpu_rdata <= cpu_we ? cpu_wdata : a_data;
        end else if (state_q == FS_FILL && bus_resp_valid) begin
            cpu_rdata <= cpu_we ? cpu_wdata : bus_resp_data;
        end
    end

    // next state and outputs
    always_comb begin
        state_d    = state_q;
        bus_req    = 1'b0;
        bus_cmd    = BC_NONE;
        bus_addr   = cpu_addr;
        bus_wdata  = '0;
        cpu_done   = 1'b0;
        wr_en      = 1'b0;
        wr_st      = LN_I;
        wr_tag     = c_tag;
        wr_data_en = 1'b0;
        wr_data    = cpu_wdata;
        unique case (state_q)
            FS_IDLE: begin
                if (local_done) begin
                    state_d = FS_RESP;
                    if (cpu_we) begin
                        wr_en      = 1'b1;
                        wr_st      = LN_M;
                        wr_data_en = 1'b1;
                    end
                end else if (go) begin
                    state_d = FS_REQ;
                end
            end
            FS_REQ: begin
                bus_req = 1'b1;
                if (need_wb) begin
                    bus_addr  = {a_tag, c_idx};
                    bus_wdata = a_data;
                end
                if (bus_gnt) begin
                    bus_cmd = issue_cmd;
                    if (need_wb) begin
                        wr_en  = 1'b1;
                        wr_st  = LN_I;
                        wr_tag = a_tag;
                    end else begin
                        state_d = FS_FILL;
                    end
                end
            end
            FS_FILL: begin
                if (bus_resp_valid) begin
                    state_d    = FS_RESP;
                    wr_en      = 1'b1;
                    wr_st      = cpu_we ? LN_M : LN_S;
                    wr_data_en = 1'b1;
                    wr_data    = cpu_we ? cpu_wdata : bus_resp_data;
                end
            end
            FS_RESP: begin
                cpu_done = 1'b1;
                state_d  = FS_IDLE;
            end
            default: state_d = FS_IDLE;
        endcase
    end

endmodule

// File: rtl/msi_snoop_ctrl_chk.sv
module msi_snoop_ctrl_chk #(
    parameter int ADDR_W = 8,
    parameter int IDX_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_req,
    input logic              cpu_we,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic              cpu_done,
    input logic              bus_req,
    input logic              bus_gnt,
    input logic [1:0]        bus_cmd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              snp_valid,
    input logic [1:0]        snp_cmd,
    input logic [ADDR_W-1:0] snp_addr,
    input logic              mem_inhibit
);

    p_share_fetch_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cmd == 2'd1 |-> cpu_req && !cpu_we && bus_addr == cpu_addr);

    p_own_fetch_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cmd == 2'd2 |-> cpu_req && cpu_we && bus_addr == cpu_addr);

    p_snoop_rd_demotes_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && snp_cmd == 2'd1 && snp_addr == $past(snp_addr)
         && $past(snp_valid && snp_cmd == 2'd1 && mem_inhibit)) |-> !mem_inhibit);

    p_snoop_rdx_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && snp_cmd == 2'd2 && snp_addr == $past(snp_addr)
         && $past(snp_valid && snp_cmd == 2'd2)) |-> !mem_inhibit);

    p_inhibit_on_snoop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_inhibit |-> snp_valid && (snp_cmd == 2'd1 || snp_cmd == 2'd2));

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |=> !cpu_done);

    p_snoop_defers_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && !bus_req && !cpu_done) |=> !cpu_done);

    p_writeback_victim_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cmd == 2'd3 |-> bus_addr[IDX_W-1:0] == cpu_addr[IDX_W-1:0]
                            && bus_addr != cpu_addr);

    p_cmd_granted_r12: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cmd != 2'd0 |-> bus_gnt && bus_req);

    p_req_held_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_gnt) |=> bus_req);

endmodule

bind msi_snoop_ctrl msi_snoop_ctrl_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cpu_req     (cpu_req),
    .cpu_we      (cpu_we),
    .cpu_addr    (cpu_addr),
    .cpu_done    (cpu_done),
    .bus_req     (bus_req),
    .bus_gnt     (bus_gnt),
    .bus_cmd     (bus_cmd),
    .bus_addr    (bus_addr),
    .snp_valid   (snp_valid),
    .snp_cmd     (snp_cmd),
    .snp_addr    (snp_addr),
    .mem_inhibit (mem_inhibit)
);

// File: tb/test_msi_snoop_ctrl.sv
module test_msi_snoop_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 8;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_req = 1'b0, cpu_we = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [DW-1:0] cpu_wdata = '0;
    logic [DW-1:0] cpu_rdata;
    logic          cpu_done, bus_req, bus_gnt;
    logic [1:0]    bus_cmd;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata;
    logic          resp_valid;
    logic [DW-1:0] resp_data;
    logic          snp_valid = 1'b0;
    logic [1:0]    snp_cmd = 2'd0;
    logic [AW-1:0] snp_addr = '0;
    logic          mem_inhibit;
    logic [DW-1:0] supply_data;
    logic          gnt_en = 1'b1;

    int checks = 0, errors = 0;
    bit finished = 1'b0;

    logic [DW-1:0] mem [256];
    logic [1:0]    log_cmd  [32];
    logic [AW-1:0] log_addr [32];
    logic [DW-1:0] log_data [32];
    int            log_n;

    always #(CLK_PERIOD/2) clk = ~clk;
    assign bus_gnt = bus_req && gnt_en;

    msi_snoop_ctrl #(.ADDR_W(AW), .DATA_W(DW), .LINES(4)) i_msi_snoop_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .cpu_done(cpu_done),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_resp_valid(resp_valid), .bus_resp_data(resp_data),
        .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
        .mem_inhibit(mem_inhibit), .supply_data(supply_data)
    );

    function automatic logic [DW-1:0] init_word(input logic [AW-1:0] a);
        return 16'h1000 + DW'(a) * 16'd7;
    endfunction

    // memory and bus log model
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] = init_word(AW'(i));
            resp_valid <= 1'b0;
            resp_data  <= '0;
            log_n      <= 0;
        end else begin
            resp_valid <= 1'b0;
            if (bus_cmd == 2'd1 || bus_cmd == 2'd2) begin
                resp_valid <= 1'b1;
                resp_data  <= mem[bus_addr];
            end
            if (bus_cmd == 2'd3) mem[bus_addr] <= bus_wdata;
            if (snp_valid && mem_inhibit && snp_cmd == 2'd1) mem[snp_addr] <= supply_data;
            if (bus_cmd != 2'd0 && log_n < 32) begin
                log_cmd[log_n]  <= bus_cmd;
                log_addr[log_n] <= bus_addr;
                log_data[log_n] <= bus_wdata;
                log_n           <= log_n + 1;
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic cpu_op(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                          output logic [DW-1:0] rd, output int cyc);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
        cyc = 0;
        forever begin
            @(negedge clk);
            cyc++;
            if (cpu_done || cyc > 100) break;
        end
        rd = cpu_rdata;
        cpu_req = 1'b0;
    endtask

    task automatic snoop(input logic [1:0] c, input logic [AW-1:0] a,
                         output logic inh, output logic [DW-1:0] dat);
        @(negedge clk);
        gnt_en = 1'b0;
        snp_valid = 1'b1; snp_cmd = c; snp_addr = a;
        #1;
        inh = mem_inhibit;
        dat = supply_data;
        @(negedge clk);
        snp_valid = 1'b0; snp_cmd = 2'd0;
        gnt_en = 1'b1;
    endtask

    task automatic t_reset;
        logic inh; logic [DW-1:0] dat;
        check(cpu_done == 1'b0, "R11", "cpu_done after reset", int'(cpu_done), 0);
        check(bus_req == 1'b0, "R11", "bus_req after reset", int'(bus_req), 0);
        check(bus_cmd == 2'd0, "R11", "bus_cmd after reset", int'(bus_cmd), 0);
        snoop(2'd2, 8'h10, inh, dat);
        check(inh == 1'b0, "R11", "inhibit on empty cache", int'(inh), 0);
    endtask

    task automatic t_read_miss_hit;
        logic [DW-1:0] rd; int cyc; int l0;
        l0 = log_n;
        cpu_op(1'b0, 8'h10, '0, rd, cyc);
        check(log_n == l0 + 1, "R1", "commands on read miss", log_n - l0, 1);
        check(log_cmd[l0] == 2'd1 && log_addr[l0] == 8'h10, "R1", "read-for-share cmd",
              int'(log_cmd[l0]), 1);
        check(rd == init_word(8'h10), "R1", "read miss data", int'(rd), int'(init_word(8'h10)));
        check(cyc == 3, "R1", "read miss latency", cyc, 3);
        l0 = log_n;
        cpu_op(1'b0, 8'h10, '0, rd, cyc);
        check(log_n == l0, "R7", "commands on read hit", log_n - l0, 0);
        check(cyc == 1, "R7", "read hit latency", cyc, 1);
        check(rd == init_word(8'h10), "R7", "read hit data", int'(rd), int'(init_word(8'h10)));
    endtask

    task automatic t_shared_snoops;
        logic inh; logic [DW-1:0] dat, rd; int cyc; int l0;
        snoop(2'd1, 8'h10, inh, dat);
        check(inh == 1'b0, "R6", "inhibit on snooped read of Shared", int'(inh), 0);
        snoop(2'd2, 8'h10, inh, dat);
        check(inh == 1'b0, "R3", "inhibit on snooped own of Shared", int'(inh), 0);
        l0 = log_n;
        cpu_op(1'b0, 8'h10, '0, rd, cyc);
        check(log_n == l0 + 1 && log_cmd[l0] == 2'd1, "R3", "refetch after invalidation",
              log_n - l0, 1);
    endtask

    task automatic t_write_paths;
        logic [DW-1:0] rd; int cyc; int l0;
        l0 = log_n;
        cpu_op(1'b1, 8'h21, 16'hA5A5, rd, cyc);
        check(log_n == l0 + 1 && log_cmd[l0] == 2'd2 && log_addr[l0] == 8'h21, "R2",
              "read-for-ownership on write miss", int'(log_cmd[l0]), 2);
        check(cyc == 3, "R2", "write miss latency", cyc, 3);
        l0 = log_n;
        cpu_op(1'b1, 8'h21, 16'h5A5A, rd, cyc);
        check(log_n == l0, "R8", "commands on write hit", log_n - l0, 0);
        check(cyc == 1, "R8", "write hit latency", cyc, 1);
        cpu_op(1'b0, 8'h21, '0, rd, cyc);
        check(rd == 16'h5A5A && log_n == l0, "R2", "read of owned line", int'(rd), 16'h5A5A);
    endtask

    task automatic t_modified_snoops;
        logic inh; logic [DW-1:0] dat, rd; int cyc; int l0;
        snoop(2'd1, 8'h21, inh, dat);
        check(inh == 1'b1, "R4", "inhibit on snooped read of Modified", int'(inh), 1);
        check(dat == 16'h5A5A, "R4", "supplied word", int'(dat), 16'h5A5A);
        l0 = log_n;
        cpu_op(1'b0, 8'h21, '0, rd, cyc);
        check(log_n == l0 && rd == 16'h5A5A, "R4", "read hit after demotion", int'(rd), 16'h5A5A);
        cpu_op(1'b1, 8'h21, 16'h1234, rd, cyc);
        check(log_n == l0 + 1 && log_cmd[l0] == 2'd2, "R4", "write on Shared upgrades",
              int'(log_cmd[l0]), 2);
        snoop(2'd2, 8'h21, inh, dat);
        check(inh == 1'b1 && dat == 16'h1234, "R5", "supply on snooped own of Modified",
              int'(dat), 16'h1234);
        snoop(2'd2, 8'h21, inh, dat);
        check(inh == 1'b0, "R5", "no supply after invalidation", int'(inh), 0);
        l0 = log_n;
        cpu_op(1'b0, 8'h21, '0, rd, cyc);
        check(log_n == l0 + 1 && log_cmd[l0] == 2'd1, "R5", "refetch after invalidation",
              log_n - l0, 1);
        check(rd == 16'h5A5A, "R4", "memory took earlier supplied word", int'(rd), 16'h5A5A);
    endtask

    task automatic t_eviction;
        logic [DW-1:0] rd; int cyc; int l0;
        cpu_op(1'b1, 8'h32, 16'hBEEF, rd, cyc);
        @(negedge clk);
        gnt_en = 1'b0;
        l0 = log_n;
        fork
            cpu_op(1'b0, 8'h42, '0, rd, cyc);
            begin
                repeat (3) @(negedge clk);
                check(bus_req == 1'b1, "R12", "bus_req held without grant", int'(bus_req), 1);
                check(log_n == l0, "R12", "no command without grant", log_n - l0, 0);
                gnt_en = 1'b1;
            end
        join
        check(log_n == l0 + 2, "R10", "commands on dirty eviction", log_n - l0, 2);
        check(log_cmd[l0] == 2'd3 && log_addr[l0] == 8'h32, "R10", "write-back first",
              int'(log_cmd[l0]), 3);
        check(log_data[l0] == 16'hBEEF, "R10", "write-back word", int'(log_data[l0]), 16'hBEEF);
        check(log_cmd[l0+1] == 2'd1 && log_addr[l0+1] == 8'h42, "R10", "fetch after write-back",
              int'(log_cmd[l0+1]), 1);
        check(rd == init_word(8'h42), "R10", "data of new line", int'(rd), int'(init_word(8'h42)));
        l0 = log_n;
        cpu_op(1'b0, 8'h32, '0, rd, cyc);
        check(log_n == l0 + 1 && log_cmd[l0] == 2'd1, "R10", "clean victim not written back",
              log_n - l0, 1);
        check(rd == 16'hBEEF, "R10", "written-back word reread", int'(rd), 16'hBEEF);
    endtask

    task automatic t_conflict;
        logic [DW-1:0] rd; logic inh; logic [DW-1:0] dat; int cyc; int l0;
        cpu_op(1'b1, 8'h13, 16'h7777, rd, cyc);
        @(negedge clk);
        l0 = log_n;
        gnt_en = 1'b0;
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 8'h13;
        snp_valid = 1'b1; snp_cmd = 2'd2; snp_addr = 8'h13;
        #1;
        inh = mem_inhibit; dat = supply_data;
        @(negedge clk);
        snp_valid = 1'b0; snp_cmd = 2'd0; gnt_en = 1'b1;
        cyc = 1;
        forever begin
            if (cpu_done || cyc > 100) break;
            @(negedge clk);
            cyc++;
        end
        rd = cpu_rdata;
        cpu_req = 1'b0;
        check(inh == 1'b1 && dat == 16'h7777, "R9", "snoop served in shared cycle",
              int'(dat), 16'h7777);
        check(log_n == l0 + 1 && log_cmd[l0] == 2'd1 && log_addr[l0] == 8'h13, "R9",
              "request re-evaluated as miss", log_n - l0, 1);
        check(cyc == 4, "R9", "deferred read latency", cyc, 4);
        check(rd == init_word(8'h13), "R9", "deferred read data", int'(rd), int'(init_word(8'h13)));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_read_miss_hit();
        t_shared_snoops();
        t_write_paths();
        t_modified_snoops();
        t_eviction();
        t_conflict();
        repeat (2) @(negedge clk);
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule